// File: doc/BRIEF.md
# Supply Monitor Interrupt Register

This block is the digital side of a brown-out monitor. A single memory-mapped word lets software switch the analog low-supply detector on or off and pick which of two supply thresholds it compares against. The detector returns one asynchronous comparator level. The block passes that level through a synchronizer and shows it as a read-only status bit. When the enabled monitor sees the supply drop below the threshold, the block latches a sticky interrupt flag.

The flag drives two interrupt request lines toward the processor, one for normal interrupts and one for fast interrupts. Each line is gated by its own mask input. Software clears the flag by writing a one to it. That clear is refused while the supply is still reported low, so code cannot resume until a safe level has returned. Access is through a simple synchronous bus. Writes take effect on the clock edge, and read data is a combinational function of the address.

Top module: `supmon_regblk`

## Requirements
- R1: After reset, a read of the register address returns 0x00000008, and `mon_en_o`, `trip_hi_o`, `norm_irq_o` and `fast_irq_o` are all 0.
- R2: A write to the register address loads bit 1 into the monitor enable and bit 2 into the threshold select. Both read back at those positions and drive `mon_en_o` and `trip_hi_o` from the next cycle on. Bits 31..4 always read 0, and writes to bit 3 are ignored.
- R3: Read bit 3 shows the supply status. When the monitor is enabled, it shows the comparator input delayed through two clock edges. When the monitor is disabled, it shows 1.
- R4: While the monitor is enabled and the status is 0, the flag (read bit 0) is 1 from the next clock edge on.
- R5: While the monitor is disabled, the flag is never set, whatever the comparator input does.
- R6: Writing 1 to bit 0 clears the flag at that clock edge only if the status is 1 in that cycle. A write-1 while the status is 0 leaves the flag at 1. Writing 0 to bit 0 never changes the flag.
- R7: A write to any other address changes no register bit, and a read of any other address returns 0.
- R8: `norm_irq_o` equals the flag ANDed with `norm_mask_i`, and `fast_irq_o` equals the flag ANDed with `fast_mask_i`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_async_i | input | 1 | Raw comparator level, 1 = supply above threshold |
| bus_addr_i | input | 32 | Bus address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| mon_en_o | output | 1 | Detector enable to the analog side |
| trip_hi_o | output | 1 | Threshold select, 1 = higher threshold |
| norm_mask_i | input | 1 | Mask for the normal interrupt request |
| fast_mask_i | input | 1 | Mask for the fast interrupt request |
| norm_irq_o | output | 1 | Normal interrupt request |
| fast_irq_o | output | 1 | Fast interrupt request |

## Verification
Random cycles mix comparator levels that toggle at random with pulses that last only one or two cycles. This separates a design that uses the raw input from one that uses the two-stage delayed level. Random writes hit the register address and other addresses, with all combinations of bit 0 and of the enable. This exposes a clear that is not gated by status, a set that is not gated by enable, and address decoding errors. Directed sequences then hold the comparator low across a clear attempt, release it and clear again, write 0 to the flag, and step through all four mask combinations. Each of these cases isolates one requirement.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  // bit positions inside the register word
  localparam int unsigned FLAG_BIT = 0;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned TRIP_BIT = 2;
  localparam int unsigned STAT_BIT = 3;

  typedef struct packed {
    logic trip;
    logic en;
  } supmon_ctrl_t;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output supmon_ctrl_t      ctrl_o
);
  supmon_ctrl_t ctrl_q, ctrl_d;
  logic         ctrl_ce;

  always_comb begin
    ctrl_ce     = wr_hit_i;
    ctrl_d.en   = wdata_i[EN_BIT];
    ctrl_d.trip = wdata_i[TRIP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/supmon_flag.sv
module supmon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_req_i,
  input  logic ok_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_ce;

  // a hardware set wins over a clear in the same cycle
  always_comb begin
    flag_ce = set_i | (clr_req_i & ok_i);
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/supmon_regblk.sv
module supmon_regblk
  import supmon_pkg::*;
#(
  parameter int unsigned          ADDR_W      = 32,
  parameter int unsigned          DATA_W      = 32,
  parameter logic [ADDR_W-1:0]    REG_ADDR    = 32'hFFFF_0440,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_async_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              mon_en_o,
  output logic              trip_hi_o,
  input  logic              norm_mask_i,
  input  logic              fast_mask_i,
  output logic              norm_irq_o,
  output logic              fast_irq_o
);
  localparam int unsigned USED_BITS = STAT_BIT + 1;

  logic         addr_hit, wr_hit;
  logic         cmp_sync;
  logic         cmp_ok;
  logic         flag_q;
  logic         set_low;
  supmon_ctrl_t ctrl;

  assign addr_hit = (bus_addr_i == REG_ADDR);
  assign wr_hit   = bus_we_i & addr_hit;

  supmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_async_i), .q_o(cmp_sync)
  );

  supmon_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_hit_i(wr_hit), .wdata_i(bus_wdata_i), .ctrl_o(ctrl)
  );

  // status reads healthy whenever the detector is off
  assign cmp_ok  = ~ctrl.en | cmp_sync;
  assign set_low = ctrl.en & ~cmp_sync;

  supmon_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(set_low),
    .clr_req_i(wr_hit & bus_wdata_i[FLAG_BIT]), .ok_i(cmp_ok), .flag_o(flag_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (addr_hit) begin
      bus_rdata_o[FLAG_BIT] = flag_q;
      bus_rdata_o[EN_BIT]   = ctrl.en;
      bus_rdata_o[TRIP_BIT] = ctrl.trip;
      bus_rdata_o[STAT_BIT] = cmp_ok;
    end
  end

  assign mon_en_o   = ctrl.en;
  assign trip_hi_o  = ctrl.trip;
  assign norm_irq_o = flag_q & norm_mask_i;
  assign fast_irq_o = flag_q & fast_mask_i;

  initial begin
    if (DATA_W < USED_BITS) $error("DATA_W too small");
  end
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk #(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 32'hFFFF_0440
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic              mon_en_o,
  input logic              trip_hi_o,
  input logic              cmp_ok,
  input logic              flag_q,
  input logic              norm_mask_i,
  input logic              fast_mask_i,
  input logic              norm_irq_o,
  input logic              fast_irq_o
);
  p_status_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en_o |-> cmp_ok);
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en_o && !cmp_ok) |=> flag_q);
  p_no_set_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en_o && !flag_q) |=> !flag_q);
  p_clr_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !cmp_ok) |=> flag_q);
  p_other_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && bus_addr_i != REG_ADDR) |=> ($stable(mon_en_o) && $stable(trip_hi_o)));
  p_mask_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_mask_i |-> !norm_irq_o);
  p_mask_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_mask_i |-> !fast_irq_o);
endmodule

bind supmon_regblk supmon_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
  .mon_en_o(mon_en_o), .trip_hi_o(trip_hi_o), .cmp_ok(cmp_ok), .flag_q(flag_q),
  .norm_mask_i(norm_mask_i), .fast_mask_i(fast_mask_i),
  .norm_irq_o(norm_irq_o), .fast_irq_o(fast_irq_o)
);

// File: tb/sim_supmon_regblk.sv
`timescale 1ns/1ps
module sim_supmon_regblk;
  localparam logic [31:0] RA = 32'hFFFF_0440;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp = 1'b1;
  logic [31:0] addr = RA;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        nmask = 1'b0, fmask = 1'b0;
  logic [31:0] rdata;
  logic        en_o, trip_o, nirq, firq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference state
  logic m_en = 0, m_trip = 0, m_flag = 0, m_s1 = 1, m_s2 = 1;

  always #10 clk = ~clk;

  supmon_regblk u0 (
    .clk(clk), .rst_n(rst_n), .cmp_async_i(cmp), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mon_en_o(en_o), .trip_hi_o(trip_o),
    .norm_mask_i(nmask), .fast_mask_i(fmask), .norm_irq_o(nirq), .fast_irq_o(firq)
  );

  function automatic logic m_ok();
    return !m_en || m_s2;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [31:0] a);
    if (a != RA) return 32'h0;
    return {28'h0, m_ok(), m_trip, m_en, m_flag};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive after the falling edge, compare, then model the rising edge
  task automatic step(input logic c, input logic w, input logic [31:0] a,
                      input logic [31:0] d, input logic nm, input logic fm);
    logic set_v, clr_v, hit;
    @(negedge clk);
    cmp = c; we = w; addr = a; wdata = d; nmask = nm; fmask = fm;
    #2;
    check("R2 R3 R7 read", rdata, exp_rdata(a));
    check("R8 irq", {30'h0, firq, nirq}, {30'h0, m_flag & fm, m_flag & nm});
    check("R2 outputs", {30'h0, trip_o, en_o}, {30'h0, m_trip, m_en});
    @(posedge clk);
    hit   = w && (a == RA);
    set_v = m_en && !m_s2;
    clr_v = hit && d[0] && m_ok();
    m_flag = set_v ? 1'b1 : (clr_v ? 1'b0 : m_flag);
    if (hit) begin m_en = d[1]; m_trip = d[2]; end
    m_s2 = m_s1;
    m_s1 = c;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    #1 check("R1 reset word", rdata, 32'h0000_0008);
    check("R1 reset outputs", {28'h0, en_o, trip_o, nirq, firq}, 32'h0);

    // R2: enable with high threshold, bit3 write ignored, upper bits read 0
    step(1, 1, RA, 32'hFFFF_FFF6, 0, 0);
    step(1, 0, RA, 0, 0, 0);
    check("R2 readback", rdata, 32'h0000_000E);

    // R4 / R6: low supply sets flag, clear blocked while low
    step(0, 0, RA, 0, 1, 1);
    step(0, 0, RA, 0, 1, 1);
    step(0, 0, RA, 0, 1, 1);
    step(0, 1, RA, 32'h3, 1, 1);
    step(0, 0, RA, 0, 1, 1);
    check("R4 flag set", {31'h0, rdata[0]}, 32'h1);
    check("R6 clear blocked", {31'h0, m_flag}, 32'h1);
    // recover, write 0 first (no effect), then write 1
    step(1, 0, RA, 0, 1, 0);
    step(1, 0, RA, 0, 1, 0);
    step(1, 1, RA, 32'h2, 1, 0);
    step(1, 0, RA, 0, 1, 0);
    check("R6 write0 no effect", {31'h0, rdata[0]}, 32'h1);
    step(1, 1, RA, 32'h3, 0, 1);
    step(1, 0, RA, 0, 0, 1);
    check("R6 cleared", {31'h0, rdata[0]}, 32'h0);

    // R5: disabled monitor ignores low comparator, status reads 1
    step(1, 1, RA, 32'h0, 1, 1);
    for (int i = 0; i < 5; i++) step(0, 0, RA, 0, 1, 1);
    check("R5 no set when off", rdata, 32'h0000_0008);

    // R7: writes elsewhere have no effect
    step(0, 1, RA + 4, 32'h7, 1, 1);
    step(0, 1, 32'h0, 32'h7, 1, 1);
    step(0, 0, RA, 0, 1, 1);
    check("R7 other address", rdata, 32'h0000_0008);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [31:0] d;
      a = ($urandom % 4 == 0) ? $urandom : RA;
      d = $urandom;
      if ($urandom % 3 == 0) d[1] = 1'b1;
      step($urandom % 3 != 0, $urandom % 4 == 0, a, d, $urandom % 2, $urandom % 2);
    end
    finish_run();
  end
endmodule